// File: doc/BRIEF.md
# Duplicated-Hamming Link Codec with Parity-Steered Copy Selection

This block protects 32-bit flits on a switch-to-switch link of an on-chip network. The transmit side builds a 38-bit single-error-correcting Hamming codeword and drives it twice. The two copies are bit-interleaved, so each wire runs beside a wire that carries the same value. This removes opposite-direction transitions between neighbours and so limits coupling noise. One more wire carries the even parity of the codeword, for 77 wires in all. The word on the link has a minimum distance of seven.

The receive side recomputes the parity of the first copy and computes its syndrome. From these it decides which copy to trust, then Hamming-corrects the chosen copy. It returns the data with three flags: a bit was corrected, the chosen copy was uncorrectable, and the second copy was used. Both paths are combinational between an output register on the transmit side and an output register on the receive side, so each path fits in one link cycle. Retransmission, link pipelining and switch logic sit outside this block.

Top module: `xtalk_dec_codec`

## Requirements
- R1: The codeword uses Hamming positions 1 to 38, with codeword bit p-1 holding position p. Check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bits 0 to 31 fill the remaining positions in ascending order. Check bit 2^k makes the XOR over all positions whose index has bit k set equal to zero.
- R2: On `tx_link_o`, wire 2i carries copy A bit i and wire 2i+1 carries copy B bit i, for i from 0 to 37. Wire 76 carries the XOR of the 38 codeword bits.
- R3: The receiver uses copy B, and raises `rx_used_b_o`, when the received wire 76 differs from the XOR of received copy A, or when copy A's syndrome is nonzero. Otherwise it uses copy A.
- R4: When the chosen copy's syndrome s lies in 1..38, position s is inverted before the data is extracted, and `rx_corrected_o` is 1.
- R5: When the chosen copy's syndrome lies in 39..63, `rx_uncorrectable_o` is 1 and the data bits of the chosen copy are returned unmodified. The corrected and uncorrectable flags are never high together.
- R6: For any pattern of one or two flipped wires among the 77, `rx_data_o` equals the transmitted data exactly.
- R7: `tx_link_o` shows the encoding of `tx_data_i` one clock after it is sampled. The receive outputs reflect `rx_link_i` one clock after it is sampled.
- R8: While `rst_n` is low, all outputs of the block are zero.
- R9: An error-free link word gives copy A in use, both correction flags low, and the original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low reset |
| tx_data_i | input | 32 | Flit data to encode |
| tx_link_o | output | 77 | Registered link word toward the wires |
| rx_link_i | input | 77 | Link word received from the wires |
| rx_data_o | output | 32 | Recovered flit data |
| rx_corrected_o | output | 1 | A single bit of the chosen copy was repaired |
| rx_uncorrectable_o | output | 1 | The chosen copy's syndrome names no valid position |
| rx_used_b_o | output | 1 | Copy B was chosen |

## Verification
The clocked properties take for granted that `rx_link_i` is driven to known values in every cycle after reset. They make no assumption about how many wires are wrong. The parity-steering and flag-exclusion properties hold for any received word. The exact-recovery property depends on at most two flipped wires, so every exhaustive single- and double-flip case is compared against the original data. Random triple flips are only compared against a bench model of the selection and correction rules, never against the original data. The bench drives the transmit output back into the receive input through an error mask, so the receiver sees only words that began as valid encodings.

// File: rtl/xdc_pkg.sv
package xdc_pkg;

    localparam int DATA_W = 32;

    function automatic int chk_bits(input int d);
        for (int r = 1; r < 31; r++) begin
            if ((1 << r) >= d + r + 1) return r;
        end
        return 31;
    endfunction

    localparam int CHK_W  = chk_bits(DATA_W);
    localparam int CW_W   = DATA_W + CHK_W;
    localparam int LINK_W = 2 * CW_W + 1;

    function automatic bit is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic int log2_exact(input int p);
        for (int k = 0; k < 31; k++) begin
            if ((1 << k) == p) return k;
        end
        return 0;
    endfunction

    // Position (1-based) of data bit j within the codeword
    function automatic int data_pos(input int j);
        int cnt;
        cnt = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == j) return p;
                cnt++;
            end
        end
        return 1;
    endfunction

    // Data positions covered by check bit k
    function automatic logic [CW_W-1:0] cover_mask(input int k);
        logic [CW_W-1:0] m;
        m = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_pow2(p) && (((p >> k) & 1) == 1)) m[p-1] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [CHK_W-1:0] syndrome(input logic [CW_W-1:0] cw);
        logic [CHK_W-1:0] s;
        s = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (cw[p-1]) s ^= CHK_W'(p);
        end
        return s;
    endfunction

    // One-hot inversion mask, empty when the syndrome names no position
    function automatic logic [CW_W-1:0] flip_mask(input logic [CHK_W-1:0] s);
        logic [CW_W-1:0] m;
        m = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (s == CHK_W'(p)) m[p-1] = 1'b1;
        end
        return m;
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              corrected;
        logic              uncorrectable;
        logic              used_b;
    } rx_result_t;

endpackage

// File: rtl/xdc_encoder.sv
module xdc_encoder
    import xdc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [LINK_W-1:0] link_o
);

    logic [CW_W-1:0]  placed;
    logic [CW_W-1:0]  cw;
    logic [CHK_W-1:0] chk;

    // R1: data in non-power-of-two positions, check bits in the others
    for (genvar p = 1; p <= CW_W; p++) begin : g_pos
        if (is_pow2(p)) begin : g_chk
            assign placed[p-1] = 1'b0;
            assign cw[p-1]     = chk[log2_exact(p)];
        end else begin : g_dat
            assign placed[p-1] = data_i[data_pos(0) == p ? 0 : p - 1 - (log2_exact(1) + $clog2(p + 1))];
            assign cw[p-1]     = placed[p-1];
        end
    end

    for (genvar k = 0; k < CHK_W; k++) begin : g_chkbit
        assign chk[k] = ^(placed & cover_mask(k));
    end

    // R2: interleaved duplicates plus overall parity
    for (genvar i = 0; i < CW_W; i++) begin : g_wire
        assign link_o[2*i]   = cw[i];
        assign link_o[2*i+1] = cw[i];
    end
    assign link_o[LINK_W-1] = ^cw;

endmodule

// File: rtl/xdc_select.sv
module xdc_select
    import xdc_pkg::*;
(
    input  logic [LINK_W-1:0] link_i,
    output logic [DATA_W-1:0] data_sel_o,
    output logic [CHK_W-1:0]  syn_o,
    output logic              used_b_o
);

    logic [CW_W-1:0]  cp_a;
    logic [CW_W-1:0]  cp_b;
    logic [CW_W-1:0]  cp_sel;
    logic [CHK_W-1:0] syn_a;
    logic [CHK_W-1:0] syn_b;
    logic             par_mis;

    for (genvar i = 0; i < CW_W; i++) begin : g_split
        assign cp_a[i] = link_i[2*i];
        assign cp_b[i] = link_i[2*i+1];
    end

    always_comb begin
        syn_a    = syndrome(cp_a);
        syn_b    = syndrome(cp_b);
        par_mis  = (^cp_a) != link_i[LINK_W-1];
        // R3: parity disagreement or a damaged copy A steers to copy B
        used_b_o = par_mis | (syn_a != '0);
        cp_sel   = used_b_o ? cp_b : cp_a;
        syn_o    = used_b_o ? syn_b : syn_a;
    end

    for (genvar j = 0; j < DATA_W; j++) begin : g_ext
        assign data_sel_o[j] = cp_sel[data_pos(j) - 1];
    end

endmodule

// File: rtl/xdc_correct.sv
module xdc_correct
    import xdc_pkg::*;
(
    input  logic [DATA_W-1:0] data_sel_i,
    input  logic [CHK_W-1:0]  syn_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corrected_o,
    output logic              uncorrectable_o
);

    logic [CW_W-1:0] flip;

    always_comb begin
        flip            = flip_mask(syn_i);
        corrected_o     = |flip;                          // R4
        uncorrectable_o = (syn_i != '0) && !(|flip);      // R5
    end

    for (genvar j = 0; j < DATA_W; j++) begin : g_fix
        assign data_o[j] = data_sel_i[j] ^ flip[data_pos(j) - 1];
    end

endmodule

// File: rtl/xtalk_dec_codec.sv
module xtalk_dec_codec
    import xdc_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       tx_data_i,
    output logic [76:0]       tx_link_o,
    input  logic [76:0]       rx_link_i,
    output logic [31:0]       rx_data_o,
    output logic              rx_corrected_o,
    output logic              rx_uncorrectable_o,
    output logic              rx_used_b_o
);

    logic [LINK_W-1:0] tx_link_c;
    logic [DATA_W-1:0] sel_data;
    logic [CHK_W-1:0]  sel_syn;
    rx_result_t        rx_c;
    rx_result_t        rx_q;

    xdc_encoder u_enc (
        .data_i (tx_data_i),
        .link_o (tx_link_c)
    );

    xdc_select u_sel (
        .link_i     (rx_link_i),
        .data_sel_o (sel_data),
        .syn_o      (sel_syn),
        .used_b_o   (rx_c.used_b)
    );

    xdc_correct u_cor (
        .data_sel_i      (sel_data),
        .syn_i           (sel_syn),
        .data_o          (rx_c.data),
        .corrected_o     (rx_c.corrected),
        .uncorrectable_o (rx_c.uncorrectable)
    );

    if (OUT_REG) begin : g_reg
        logic [LINK_W-1:0] tx_q;

        // R7, R8: one register stage per direction, cleared in reset
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tx_q <= '0;
                rx_q <= '0;
            end else begin
                tx_q <= tx_link_c;
                rx_q <= rx_c;
            end
        end
        assign tx_link_o = tx_q;

        logic [CW_W-1:0] tx_a, tx_b, rx_a, rx_b;
        for (genvar i = 0; i < CW_W; i++) begin : g_chk_split
            assign tx_a[i] = tx_link_o[2*i];
            assign tx_b[i] = tx_link_o[2*i+1];
            assign rx_a[i] = rx_link_i[2*i];
            assign rx_b[i] = rx_link_i[2*i+1];
        end

        AST_ENC_CODEWORD: assert property (@(posedge clk) disable iff (!rst_n)
            syndrome(tx_a) == '0);                                                   // R1
        AST_ENC_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_a == tx_b) && (tx_link_o[LINK_W-1] == ^tx_a));                       // R2
        AST_PARITY_PICKS_B: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_link_i[LINK_W-1] != ^rx_a) |=> rx_used_b_o);                          // R3
        AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            !(rx_corrected_o && rx_uncorrectable_o));                                // R5
        AST_CLEAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            ((rx_a == rx_b) && (rx_link_i[LINK_W-1] == ^rx_a) && (syndrome(rx_a) == '0))
            |=> (!rx_used_b_o && !rx_corrected_o && !rx_uncorrectable_o));           // R9
    end else begin : g_comb
        assign tx_link_o = tx_link_c;
        assign rx_q      = rx_c;
    end

    assign rx_data_o          = rx_q.data;
    assign rx_corrected_o     = rx_q.corrected;
    assign rx_uncorrectable_o = rx_q.uncorrectable;
    assign rx_used_b_o        = rx_q.used_b;

endmodule

// File: tb/xtalk_dec_codec_tb.sv
`timescale 1ns/1ps
module xtalk_dec_codec_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data = '0;
    logic [76:0] err = '0;
    logic [76:0] tx_link;
    logic [76:0] rx_link;
    logic [31:0] rx_data;
    logic        rx_corr, rx_unc, rx_usedb;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    assign rx_link = tx_link ^ err;

    xtalk_dec_codec u_dut (
        .clk                (clk),
        .rst_n              (rst_n),
        .tx_data_i          (data),
        .tx_link_o          (tx_link),
        .rx_link_i          (rx_link),
        .rx_data_o          (rx_data),
        .rx_corrected_o     (rx_corr),
        .rx_uncorrectable_o (rx_unc),
        .rx_used_b_o        (rx_usedb)
    );

    function automatic bit pw2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic logic [37:0] m_encode(input logic [31:0] d);
        logic [37:0] c;
        int j;
        c = '0;
        j = 0;
        for (int p = 1; p <= 38; p++) begin
            if (!pw2(p)) begin
                c[p-1] = d[j];
                j++;
            end
        end
        for (int k = 0; k < 6; k++) begin
            logic s;
            s = 1'b0;
            for (int p = 1; p <= 38; p++) begin
                if (!pw2(p) && ((p >> k) & 1) == 1) s ^= c[p-1];
            end
            c[(1 << k) - 1] = s;
        end
        return c;
    endfunction

    function automatic logic [76:0] m_link(input logic [37:0] c);
        logic [76:0] w;
        for (int i = 0; i < 38; i++) begin
            w[2*i]   = c[i];
            w[2*i+1] = c[i];
        end
        w[76] = ^c;
        return w;
    endfunction

    function automatic logic [31:0] m_extract(input logic [37:0] c);
        logic [31:0] d;
        int j;
        j = 0;
        d = '0;
        for (int p = 1; p <= 38; p++) begin
            if (!pw2(p)) begin
                d[j] = c[p-1];
                j++;
            end
        end
        return d;
    endfunction

    // returns {data, corrected, uncorrectable, used_b}
    function automatic logic [34:0] m_decode(input logic [31:0] d, input logic [76:0] m);
        logic [37:0] ea, eb, es;
        int sa, sb, s;
        logic selb, corr, unc;
        sa = 0;
        sb = 0;
        for (int i = 0; i < 38; i++) begin
            ea[i] = m[2*i];
            eb[i] = m[2*i+1];
            if (ea[i]) sa ^= i + 1;
            if (eb[i]) sb ^= i + 1;
        end
        selb = ((^ea) ^ m[76]) || (sa != 0);
        s    = selb ? sb : sa;
        es   = selb ? eb : ea;
        corr = (s >= 1) && (s <= 38);
        unc  = s > 38;
        if (corr) es[s-1] = ~es[s-1];
        return {d ^ m_extract(es), corr, unc, selb};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [31:0] d, input logic [76:0] m, input string tag);
        logic [34:0] e;
        @(negedge clk);
        data = d;
        err  = m;
        @(posedge clk);
        @(negedge clk);
        check({"R1 R2 R7 link ", tag}, 128'(tx_link), 128'(m_link(m_encode(d))));
        @(posedge clk);
        @(negedge clk);
        e = m_decode(d, m);
        check({"R6 R7 data ", tag}, 128'(rx_data), 128'(e[34:3]));
        check({"R4 corrected ", tag}, 128'(rx_corr), 128'(e[2]));
        check({"R5 uncorrectable ", tag}, 128'(rx_unc), 128'(e[1]));
        check({"R3 used_b ", tag}, 128'(rx_usedb), 128'(e[0]));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [76:0] m;
        void'($urandom(32'd20240611));

        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 tx_link reset", 128'(tx_link), 128'(0));
        check("R8 rx outputs reset", 128'({rx_data, rx_corr, rx_unc, rx_usedb}), 128'(0));
        rst_n = 1'b1;

        // R9: clean link
        run_case(32'h0000_0000, '0, "R9 zero");
        run_case(32'hFFFF_FFFF, '0, "R9 ones");
        run_case(32'hA5A5_5A5A, '0, "R9 pattern");
        for (int t = 0; t < 20; t++) run_case($urandom, '0, "R9 random");

        // R3: parity wire alone flipped, copy B clean
        run_case(32'h1234_5678, 77'(1) << 76, "R3 parity only");
        // R4: parity plus copy B position 5 flipped
        run_case(32'hDEAD_BEEF, (77'(1) << 76) | (77'(1) << 9), "R4 fix B");
        // R5: parity plus copy B positions 38 and 1 -> syndrome 39
        d = 32'hCAFE_F00D;
        run_case(d, (77'(1) << 76) | (77'(1) << 75) | (77'(1) << 1), "R5 directed");
        check("R5 raw B data", 128'(rx_data), 128'(d ^ 32'h8000_0000));
        check("R5 flag", 128'(rx_unc), 128'(1));

        // R6: every single wire flip
        for (int a = 0; a < 77; a++) run_case($urandom, 77'(1) << a, "R6 single");
        // R6: every double wire flip
        for (int a = 0; a < 77; a++) begin
            for (int b = a + 1; b < 77; b++) begin
                run_case($urandom, (77'(1) << a) | (77'(1) << b), "R6 double");
            end
        end
        // R3 R4 R5: random triple flips against the model
        for (int t = 0; t < 300; t++) begin
            m = (77'(1) << ($urandom % 77)) | (77'(1) << ($urandom % 77)) | (77'(1) << ($urandom % 77));
            run_case($urandom, m, "triple");
        end

        finish_run();
    end

endmodule